// File: doc/BRIEF.md
# Sign-Driven Offset Coefficient Adaptation Loop

A double-sampling optical receiver front-end uses a gain coefficient to cancel a pattern-dependent part of each double-sampled voltage. This block adapts that coefficient in the digital domain at the demultiplexed word rate. Each word carries four resolved data bits and four error-comparator bits, one of each per lane. An error bit gives the sign of the difference between one double-sampled voltage and the voltage before it. Bit 0 of a word is the earliest bit, and its predecessor is bit 3 of the previous word.

Only a repeated bit pair (a bit equal to its predecessor) carries adjustment information. Such a lane casts an up or a down vote from the error sign alone. The votes of a word are summed and added to a signed accumulator. When the accumulator crosses a programmable threshold in either direction, the coefficient moves by one code and the accumulator clears. The coefficient saturates at both ends. A status output reports when the recent moves alternate in direction, which is the sign that the loop is dithering about its optimum. An enable input lets the loop run only occasionally, to follow slow drift.

Top module: `dca_coef_adapt`

## Requirements
- R1: While reset is asserted and right after it is released, `coef_o` equals the parameter COEF_INIT, and `step_o` and `dither_o` are 0.
- R2: A lane whose bit equals its predecessor votes on the error sign, where `err_i[k]`=1 means the second difference was larger than the first. For the pair 11, err=1 votes down and err=0 votes up. For the pair 00 it is the reverse: err=1 votes up and err=0 votes down.
- R3: A lane whose bit differs from its predecessor (pair 01 or 10) casts no vote, whatever its error bit.
- R4: The predecessor of lane 0 is bit 3 of the previous word. In the first word after reset, lane 0 casts no vote.
- R5: The votes are summed as (ups minus downs) and added to the accumulator. If the result is at least +T, the coefficient steps up. If it is at most -T, the coefficient steps down. After either step the accumulator clears. Otherwise the accumulator keeps the result. T is `thresh_i`, and a value of 0 acts as 1.
- R6: Each step changes `coef_o` by exactly 1, and the coefficient changes on the same clock edge as the word that caused the step. `step_o` is 1 in exactly the cycles in which `coef_o` has just changed.
- R7: `coef_o` never goes below 0 or above 2^COEF_W-1 and never wraps. A step request at a limit leaves the code unchanged, keeps `step_o` at 0 and still clears the accumulator.
- R8: While `en_i` is 0, the accumulator and the coefficient hold. The predecessor bit still follows the incoming words, so lane 0 of the first enabled word uses the latest bit.
- R9: `dither_o` is 1 when at least DITH_N coefficient moves have occurred since reset and each of the last DITH_N moves went in the opposite direction to the move before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Adaptation enable; 0 freezes accumulator and coefficient |
| data_i | input | LANES | Resolved data bits, bit 0 earliest |
| err_i | input | LANES | Error comparator signs, one per lane |
| thresh_i | input | ACC_W-1 | Filter threshold T (0 acts as 1) |
| coef_o | output | COEF_W | Unsigned coefficient code |
| step_o | output | 1 | Coefficient moved on the last edge |
| dither_o | output | 1 | Last DITH_N moves alternated |

## Verification
The bench builds the block with COEF_INIT=8, ACC_W=6 and DITH_N=4, and keeps four lanes and an 8-bit code. The low initial code lets directed runs reach the floor within a few words and the ceiling within a few hundred. The 5-bit threshold reaches from the zero-as-one case up to values that show the partial sums of the first word after reset. A four-move history lets a short run of alternating error signs raise the dithering flag, and a repeated direction then clears it. A behavioural model predicts every output on every clock, through directed patterns and a long random run with random thresholds and enable gaps.

// File: rtl/dca_pkg.sv
package dca_pkg;
  typedef enum logic [1:0] {
    VOTE_NONE = 2'd0,
    VOTE_UP   = 2'd1,
    VOTE_DN   = 2'd2
  } vote_e;
endpackage

// File: rtl/dca_lane_qual.sv
module dca_lane_qual
  import dca_pkg::*;
(
  input  logic  prev_vld_i,
  input  logic  prev_i,
  input  logic  cur_i,
  input  logic  err_i,
  output vote_e vote_o
);
  // Repeated bit: the error sign gives the direction. For 11 a positive
  // error means too much correction (down); 00 mirrors it.
  always_comb begin
    vote_o = VOTE_NONE;
    if (prev_vld_i && (prev_i == cur_i)) begin
      vote_o = (cur_i ^ err_i) ? VOTE_UP : VOTE_DN;
    end
  end
endmodule

// File: rtl/dca_vote_filter.sv
module dca_vote_filter
  import dca_pkg::*;
#(
  parameter int LANES = 4,
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  vote_e            votes_i [LANES],
  input  logic [ACC_W-2:0] thresh_i,
  output logic             inc_o,
  output logic             dec_o
);
  localparam int SUM_W = $clog2(LANES + 1) + 1;
  localparam int EXT_W = ACC_W + 1;

  logic signed [SUM_W-1:0] vsum;
  logic signed [EXT_W-1:0] nxt, thr_pos, thr_neg;
  logic [ACC_W-2:0]        thr_eff;
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic                    hit_up, hit_dn;

  always_comb begin
    vsum = '0;
    for (int i = 0; i < LANES; i++) begin
      if (votes_i[i] == VOTE_UP)      vsum = vsum + SUM_W'(1);
      else if (votes_i[i] == VOTE_DN) vsum = vsum - SUM_W'(1);
    end
  end

  always_comb begin
    thr_eff = (thresh_i == '0) ? (ACC_W-1)'(1) : thresh_i;
    thr_pos = {2'b00, thr_eff};
    thr_neg = -thr_pos;
    nxt     = {acc_q[ACC_W-1], acc_q} + {{(EXT_W-SUM_W){vsum[SUM_W-1]}}, vsum};
    hit_up  = en_i && (nxt >= thr_pos);
    hit_dn  = en_i && (nxt <= thr_neg);
    acc_d   = acc_q;
    if (en_i) begin
      if (hit_up || hit_dn) acc_d = '0;
      else                  acc_d = nxt[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign inc_o = hit_up;
  assign dec_o = hit_dn;

  AST_ACC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hit_up || hit_dn) |-> (acc_q == '0)); // R5
  AST_ACC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_i) |-> $stable(acc_q)); // R8
endmodule

// File: rtl/dca_coef_track.sv
module dca_coef_track #(
  parameter int              COEF_W    = 8,
  parameter int              DITH_N    = 4,
  parameter logic [COEF_W-1:0] COEF_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              inc_i,
  input  logic              dec_i,
  output logic [COEF_W-1:0] coef_o,
  output logic              step_o,
  output logic              dither_o
);
  localparam logic [COEF_W-1:0] COEF_MAX = '1;
  localparam int                CNT_W    = $clog2(DITH_N + 1);

  logic [COEF_W-1:0] coef_q, coef_d;
  logic              step_q, move_up, move_dn, moved;
  logic [DITH_N-1:0] dir_q, dir_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              alt;

  always_comb begin
    move_up = inc_i && (coef_q != COEF_MAX);
    move_dn = dec_i && (coef_q != '0);
    moved   = move_up || move_dn;
    coef_d  = coef_q;
    if (move_up)      coef_d = coef_q + COEF_W'(1);
    else if (move_dn) coef_d = coef_q - COEF_W'(1);
    dir_d = dir_q;
    cnt_d = cnt_q;
    if (moved) begin
      dir_d = {dir_q[DITH_N-2:0], move_up};
      if (cnt_q != CNT_W'(DITH_N)) cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_q <= COEF_INIT;
      step_q <= 1'b0;
      dir_q  <= '0;
      cnt_q  <= '0;
    end else begin
      step_q <= moved;
      if (moved) begin
        coef_q <= coef_d;
        dir_q  <= dir_d;
        cnt_q  <= cnt_d;
      end
    end
  end

  assign alt      = &(dir_q[DITH_N-2:0] ^ dir_q[DITH_N-1:1]);
  assign dither_o = (cnt_q == CNT_W'(DITH_N)) && alt;
  assign coef_o   = coef_q;
  assign step_o   = step_q;

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_q |-> ((coef_q == $past(coef_q) + COEF_W'(1)) ||
                (coef_q == $past(coef_q) - COEF_W'(1)))); // R6
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !step_q |-> $stable(coef_q)); // R6
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(coef_q) == COEF_MAX) |-> (coef_q != '0)); // R7
  AST_COEF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_i) |-> $stable(coef_q)); // R8
endmodule

// File: rtl/dca_coef_adapt.sv
module dca_coef_adapt
  import dca_pkg::*;
#(
  parameter int              LANES     = 4,
  parameter int              COEF_W    = 8,
  parameter int              ACC_W     = 8,
  parameter int              DITH_N    = 4,
  parameter logic [COEF_W-1:0] COEF_INIT = COEF_W'(128)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [LANES-1:0]  data_i,
  input  logic [LANES-1:0]  err_i,
  input  logic [ACC_W-2:0]  thresh_i,
  output logic [COEF_W-1:0] coef_o,
  output logic              step_o,
  output logic              dither_o
);
  logic  last_bit_q, last_vld_q;
  logic  pred     [LANES];
  logic  pred_vld [LANES];
  vote_e votes    [LANES];
  logic  inc, dec;

  // Last bit of the word tracks data even while adaptation is frozen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_bit_q <= 1'b0;
      last_vld_q <= 1'b0;
    end else begin
      last_bit_q <= data_i[LANES-1];
      last_vld_q <= 1'b1;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k == 0) begin : g_first
      assign pred[k]     = last_bit_q;
      assign pred_vld[k] = last_vld_q;
    end else begin : g_rest
      assign pred[k]     = data_i[k-1];
      assign pred_vld[k] = 1'b1;
    end

    dca_lane_qual u_qual (
      .prev_vld_i (pred_vld[k]),
      .prev_i     (pred[k]),
      .cur_i      (data_i[k]),
      .err_i      (err_i[k]),
      .vote_o     (votes[k])
    );

    AST_MIXED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (pred[k] != data_i[k]) |-> (votes[k] == VOTE_NONE)); // R3
  end

  dca_vote_filter #(
    .LANES (LANES),
    .ACC_W (ACC_W)
  ) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .votes_i  (votes),
    .thresh_i (thresh_i),
    .inc_o    (inc),
    .dec_o    (dec)
  );

  dca_coef_track #(
    .COEF_W    (COEF_W),
    .DITH_N    (DITH_N),
    .COEF_INIT (COEF_INIT)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .inc_i    (inc),
    .dec_i    (dec),
    .coef_o   (coef_o),
    .step_o   (step_o),
    .dither_o (dither_o)
  );

  AST_FIRST_LANE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !last_vld_q |-> (votes[0] == VOTE_NONE)); // R4
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && dec)); // R5
endmodule

// File: tb/dca_coef_adapt_bench.sv
module dca_coef_adapt_bench;
  localparam int LANES  = 4;
  localparam int COEF_W = 8;
  localparam int ACC_W  = 6;
  localparam int DITH_N = 4;
  localparam int INIT   = 8;
  localparam int CMAX   = 255;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              en_i;
  logic [LANES-1:0]  data_i, err_i;
  logic [ACC_W-2:0]  thresh_i;
  logic [COEF_W-1:0] coef_o;
  logic              step_o, dither_o;

  int tests = 0;
  int fails = 0;

  // behavioural model state
  int m_coef, m_acc, m_prev, m_vld, m_step;
  int m_dirs[$];

  always #10 clk = ~clk;

  dca_coef_adapt #(
    .LANES (LANES), .COEF_W (COEF_W), .ACC_W (ACC_W),
    .DITH_N (DITH_N), .COEF_INIT (COEF_W'(INIT))
  ) u_dca_coef_adapt (
    .clk (clk), .rst_n (rst_n), .en_i (en_i), .data_i (data_i),
    .err_i (err_i), .thresh_i (thresh_i), .coef_o (coef_o),
    .step_o (step_o), .dither_o (dither_o)
  );

  function automatic int m_dither();
    if (m_dirs.size() < DITH_N) return 0;
    for (int i = 1; i < DITH_N; i++)
      if (m_dirs[i] == m_dirs[i-1]) return 0;
    return 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic record_move(input int up);
    m_dirs.push_back(up);
    if (m_dirs.size() > DITH_N) void'(m_dirs.pop_front());
    m_step = 1;
  endtask

  task automatic model_step();
    int s = 0;
    int thr, a;
    for (int k = 0; k < LANES; k++) begin
      int p, pv;
      if (k == 0) begin p = m_prev; pv = m_vld; end
      else begin p = data_i[k-1]; pv = 1; end
      if (pv != 0 && p == int'(data_i[k]))
        s += (data_i[k] ^ err_i[k]) ? 1 : -1;
    end
    m_prev = data_i[LANES-1];
    m_vld  = 1;
    m_step = 0;
    if (en_i) begin
      thr = (thresh_i == 0) ? 1 : int'(thresh_i);
      a = m_acc + s;
      if (a >= thr) begin
        m_acc = 0;
        if (m_coef < CMAX) begin m_coef++; record_move(1); end
      end else if (a <= -thr) begin
        m_acc = 0;
        if (m_coef > 0) begin m_coef--; record_move(0); end
      end else m_acc = a;
    end
  endtask

  // one word: inputs driven at the negative edge, outputs compared at the next one
  task automatic word(input bit en, input logic [3:0] d, input logic [3:0] e, input int thr);
    en_i = en; data_i = d; err_i = e; thresh_i = (ACC_W-1)'(thr);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(int'(coef_o) == m_coef, "R6 model coef", coef_o, m_coef);
    check(int'(step_o) == m_step, "R6 model step", step_o, m_step);
    check(int'(dither_o) == m_dither(), "R9 model dither", dither_o, m_dither());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c0;
    rst_n = 1'b0; en_i = 1'b0; data_i = '0; err_i = '0; thresh_i = '0;
    m_coef = INIT; m_acc = 0; m_prev = 0; m_vld = 0; m_step = 0;
    repeat (3) @(negedge clk);
    check(coef_o == COEF_W'(INIT), "R1 reset coef", coef_o, INIT);
    check(!step_o && !dither_o, "R1 reset flags", {step_o, dither_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(coef_o == COEF_W'(INIT), "R1 coef after release", coef_o, INIT);

    // R4: the first word gets only three votes, so a threshold of 4 is not met
    word(1, 4'b1111, 4'b0000, 4);
    check(coef_o == COEF_W'(INIT), "R4 first word lane0 silent", coef_o, INIT);
    word(1, 4'b1111, 4'b0000, 4);
    check(coef_o == COEF_W'(INIT + 1), "R5 accumulate then step", coef_o, INIT + 1);
    check(step_o == 1'b1, "R6 step flag", step_o, 1);

    // R2: pair 11 with positive error votes down
    word(1, 4'b1111, 4'b1111, 1);
    check(coef_o == COEF_W'(INIT), "R2 11 err1 down", coef_o, INIT);
    // R2: pair 00 with positive error votes up (first word mixes 1->0 on lane 0)
    word(1, 4'b0000, 4'b1111, 1);
    word(1, 4'b0000, 4'b1111, 1);
    check(coef_o == COEF_W'(INIT + 2), "R2 00 err1 up", coef_o, INIT + 2);
    word(1, 4'b0000, 4'b0000, 1);
    check(coef_o == COEF_W'(INIT + 1), "R2 00 err0 down", coef_o, INIT + 1);

    // R3: alternating bits never vote
    word(1, 4'b1010, 4'b0000, 1);
    c0 = coef_o;
    for (int i = 0; i < 40; i++) word(1, 4'b1010, 4'($urandom), 1);
    check(int'(coef_o) == c0, "R3 mixed pairs silent", coef_o, c0);

    // R5: threshold 0 acts as 1
    word(1, 4'b0000, 4'b0001, 0);
    word(1, 4'b1110, 4'b0000, 0);
    check(int'(coef_o) == m_coef, "R5 zero threshold", coef_o, m_coef);

    // R8: freeze, then the predecessor must be the latest (frozen-time) bit
    word(1, 4'b1111, 4'b0000, 1);
    c0 = coef_o;
    for (int i = 0; i < 20; i++) word(0, 4'b0000, 4'($urandom), 1);
    check(int'(coef_o) == c0, "R8 frozen coef", coef_o, c0);
    word(1, 4'b0000, 4'b0000, 4);
    check(int'(coef_o) == c0 - 1, "R8 predecessor tracked", coef_o, c0 - 1);

    // R7: floor
    for (int i = 0; i < 40; i++) word(1, 4'b1111, 4'b1111, 1);
    check(coef_o == '0, "R7 floor", coef_o, 0);
    check(step_o == 1'b0, "R7 no step at floor", step_o, 0);
    // R7: ceiling
    for (int i = 0; i < 270; i++) word(1, 4'b1111, 4'b0000, 1);
    check(int'(coef_o) == CMAX, "R7 ceiling", coef_o, CMAX);
    check(step_o == 1'b0, "R7 no step at ceiling", step_o, 0);

    // R9: alternating moves raise the flag, a repeat clears it
    for (int i = 0; i < 4; i++) word(1, 4'b1111, (i % 2 == 0) ? 4'b1111 : 4'b0000, 1);
    check(dither_o == 1'b1, "R9 dither set", dither_o, 1);
    word(1, 4'b1111, 4'b1111, 1);
    word(1, 4'b1111, 4'b1111, 1);
    check(dither_o == 1'b0, "R9 dither cleared", dither_o, 0);

    // random run against the model
    for (int i = 0; i < 3000; i++)
      word(($urandom % 8) != 0, 4'($urandom), 4'($urandom), $urandom % 6);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule